// File: doc/BRIEF.md
# Signed Four-Function Arithmetic Unit

This block is a combinational arithmetic unit. It takes two narrow two's-complement operands and a two-bit operation code. It drives a wider two's-complement result that holds the sum, the difference, the product or the quotient of the operands. Both operands are sign-extended to the result width before any operation. With the default widths (4-bit operands, 8-bit result) every result is therefore exact. This includes the one quotient that overflows at operand width, -8 divided by -1.

The quotient comes from an unrolled restoring divider that works on operand magnitudes, and the sign is applied afterwards, so division truncates toward zero. A zero divisor gives a defined all-zero result. The block has no clock and no storage, and the result follows the inputs directly.

Top module: `calc_core`

## Requirements
- R1: Operands A and B are two's-complement values of OPND_W bits (default 4, range -8..+7). With op code 2'b00 the result is A + B, computed on operands sign-extended to RES_W bits (default 8) and given as RES_W-bit two's complement.
- R2: With op code 2'b01 the result is A - B, computed on the sign-extended operands.
- R3: With op code 2'b10 the result is the signed product A × B, given as RES_W-bit two's complement.
- R4: With op code 2'b11 and B nonzero, the result is the signed quotient A ÷ B, truncated toward zero. For example, -7 ÷ 2 = -3 (8'hFD) and 7 ÷ -2 = -3.
- R5: With op code 2'b11, A = -8 and B = -1, the result is +8 (8'h08).
- R6: With op code 2'b11 and B = 0, the result is 8'h00 for every A.
- R7: The result depends only on the present inputs. It takes its new value within the same clock period as an input change, with no clock edge needed, and it holds no state from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | OPND_W (4) | First operand, two's complement |
| opnd_b | input | OPND_W (4) | Second operand / divisor, two's complement |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 multiply, 11 divide |
| result | output | RES_W (8) | Signed result, two's complement |

## Verification
All 256 operand pairs are applied under each of the four op codes. The sweep covers both sign combinations, the extremes -8 and +7, and every zero operand. This separates a design that zero-extends from one that sign-extends, and one whose quotient rounds toward minus infinity from one that truncates. The sweep also reaches a zero divisor, where the result must be all zeros. Directed cases then pin down -8 ÷ -1, the two odd-quotient truncation examples, and a change of inputs with no clock edge in between, which shows the result carries no state.

// File: rtl/calc_pkg.sv
package calc_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } calc_op_e;

    localparam int unsigned OPND_W_DEF = 4;
    localparam int unsigned RES_W_DEF  = 8;

endpackage

// File: rtl/calc_addsub.sv
module calc_addsub #(
    parameter int unsigned W = calc_pkg::RES_W_DEF
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] rhs_adj;

    always_comb begin
        rhs_adj = sub ? ~rhs : rhs;
        sum     = lhs + rhs_adj + {{(W-1){1'b0}}, sub};
    end

    // R1 / R2: undoing the operation on the result must give back the first operand
    always_comb begin
        if (!$isunknown({lhs, rhs, sub})) begin
            if (!sub) begin
                a_r1_add_inverse: assert (W'(sum - rhs) == lhs)
                    else $error("add inverse broken");
            end else begin
                a_r2_sub_inverse: assert (W'(sum + rhs) == lhs)
                    else $error("sub inverse broken");
            end
        end
    end
endmodule

// File: rtl/calc_mult.sv
module calc_mult #(
    parameter int unsigned W = calc_pkg::RES_W_DEF
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] prod
);
    logic [2*W-1:0] full;

    always_comb begin
        full = lhs * rhs;
        prod = full[W-1:0];
    end
endmodule

// File: rtl/calc_divider.sv
module calc_divider #(
    parameter int unsigned W = calc_pkg::RES_W_DEF
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot
);
    logic         neg_n;
    logic         neg_d;
    logic [W-1:0] mag_n;
    logic [W-1:0] mag_d;
    logic [W-1:0] qmag;

    always_comb begin
        neg_n = dividend[W-1];
        neg_d = divisor[W-1];
        mag_n = neg_n ? W'(-dividend) : dividend;
        mag_d = neg_d ? W'(-divisor)  : divisor;
    end

    // one restoring stage per quotient bit, most significant first
    for (genvar i = 0; i < W; i++) begin : g_stage
        localparam int unsigned K = W - 1 - i;
        logic [W:0] rem_in;
        logic [W:0] trial;
        logic       fits;
        logic [W:0] rem_out;
        if (i == 0) begin : g_first
            assign rem_in = '0;
        end else begin : g_next
            assign rem_in = g_stage[i-1].rem_out;
        end
        assign trial   = {rem_in[W-1:0], mag_n[K]};
        assign fits    = trial >= {1'b0, mag_d};
        assign rem_out = fits ? (trial - {1'b0, mag_d}) : trial;
        assign qmag[K] = fits;
    end

    always_comb begin
        if (mag_d == '0)
            quot = '0;
        else if (neg_n ^ neg_d)
            quot = W'(-qmag);
        else
            quot = qmag;
    end

    // R4: the quotient magnitude is the floor of the magnitude ratio
    logic [2*W-1:0] back;
    always_comb begin
        back = qmag * mag_d;
        if (!$isunknown({dividend, divisor}) && mag_d != '0) begin
            a_r4_quot_floor: assert (back <= {{W{1'b0}}, mag_n}
                && ({{W{1'b0}}, mag_n} - back) < {{W{1'b0}}, mag_d})
                else $error("quotient magnitude is not the floor");
        end
    end
endmodule

// File: rtl/calc_core.sv
module calc_core #(
    parameter int unsigned OPND_W = calc_pkg::OPND_W_DEF,
    parameter int unsigned RES_W  = calc_pkg::RES_W_DEF
) (
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic [1:0]        op_sel,
    output logic [RES_W-1:0]  result
);
    import calc_pkg::*;

    localparam int unsigned EXT_W = RES_W - OPND_W;

    calc_op_e         op;
    logic [RES_W-1:0] ext_a;
    logic [RES_W-1:0] ext_b;
    logic [RES_W-1:0] as_res;
    logic [RES_W-1:0] mul_res;
    logic [RES_W-1:0] div_res;

    always_comb begin
        op    = calc_op_e'(op_sel);
        ext_a = {{EXT_W{opnd_a[OPND_W-1]}}, opnd_a};
        ext_b = {{EXT_W{opnd_b[OPND_W-1]}}, opnd_b};
    end

    calc_addsub #(.W(RES_W)) u_addsub (
        .lhs (ext_a),
        .rhs (ext_b),
        .sub (op == OP_SUB),
        .sum (as_res)
    );

    calc_mult #(.W(RES_W)) u_mult (
        .lhs  (ext_a),
        .rhs  (ext_b),
        .prod (mul_res)
    );

    calc_divider #(.W(RES_W)) u_div (
        .dividend (ext_a),
        .divisor  (ext_b),
        .quot     (div_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: result = as_res;
            OP_MUL:         result = mul_res;
            OP_DIV:         result = div_res;
            default:        result = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            // R6: a zero divisor yields all zeros
            if (op == OP_DIV && opnd_b == '0) begin
                a_r6_div_zero: assert (result == '0)
                    else $error("zero divisor result not zero");
            end
            // R3: a product of nonzero operands carries the xor of their signs
            if (op == OP_MUL && opnd_a != '0 && opnd_b != '0) begin
                a_r3_prod_sign: assert (result[RES_W-1] ==
                    (opnd_a[OPND_W-1] ^ opnd_b[OPND_W-1]))
                    else $error("product sign wrong");
            end
            // R5: the most negative operand over minus one stays positive
            if (op == OP_DIV && opnd_a == {1'b1, {(OPND_W-1){1'b0}}}
                && opnd_b == '1) begin
                a_r5_min_over_neg1: assert (result == RES_W'(1 << (OPND_W-1)))
                    else $error("min over -1 wrong");
            end
        end
    end
endmodule

// File: tb/sim_calc_core.sv
`timescale 1ns/1ps
module sim_calc_core;
    logic       clk = 1'b0;
    logic [3:0] a;
    logic [3:0] b;
    logic [1:0] op;
    logic [7:0] r;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    calc_core u0 (
        .opnd_a (a),
        .opnd_b (b),
        .op_sel (op),
        .result (r)
    );

    function automatic logic [7:0] model(input logic [1:0] o,
                                         input logic [3:0] x,
                                         input logic [3:0] y);
        int sx = $signed(x);
        int sy = $signed(y);
        int v;
        case (o)
            2'b00: v = sx + sy;
            2'b01: v = sx - sy;
            2'b10: v = sx * sy;
            default: v = (sy == 0) ? 0 : sx / sy;
        endcase
        return v[7:0];
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (r !== exp) begin
            fails++;
            $display("FAIL %s op=%b a=%0d b=%0d got=%h exp=%h",
                     tag, op, $signed(a), $signed(b), r, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [3:0] x,
                         input logic [3:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
    endtask

    function automatic string tag_of(input logic [1:0] o, input logic [3:0] y);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return (y == 4'd0) ? "R6" : "R4";
        endcase
    endfunction

    initial begin
        // R1: first applied pattern, 0 + 0
        apply(2'b00, 4'd0, 4'd0);
        check("R1", 8'h00);

        // full sweep of every op code and operand pair
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++) begin
                    apply(k[1:0], i[3:0], j[3:0]);
                    check(tag_of(k[1:0], j[3:0]), model(k[1:0], i[3:0], j[3:0]));
                end

        // directed corners
        apply(2'b11, 4'b1000, 4'b1111); check("R5", 8'h08);
        apply(2'b11, 4'b1001, 4'd2);    check("R4", 8'hFD);
        apply(2'b11, 4'd7, 4'b1110);    check("R4", 8'hFD);
        apply(2'b11, 4'b1000, 4'd0);    check("R6", 8'h00);
        apply(2'b00, 4'd7, 4'd7);       check("R1", 8'h0E);
        apply(2'b01, 4'b1000, 4'd7);    check("R2", 8'hF1);
        apply(2'b10, 4'b1000, 4'b1000); check("R3", 8'h40);

        // R7: change inputs twice inside one clock period
        @(negedge clk);
        op = 2'b10; a = 4'd3; b = 4'b1101;
        #0.5; check("R7", 8'hF7);
        op = 2'b00; a = 4'd5; b = 4'd1;
        #0.5; check("R7", 8'h06);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired got=hang exp=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule